// File: doc/BRIEF.md
# Delegation-Gated Supervisor Interrupt Pending View

This block keeps the machine-level interrupt pending state for four interrupt sources. It presents that state to supervisor software as a restricted 64-bit CSR at address 0x144. Two of the sources are held in flops inside the block: software interrupt and local counter overflow. The other two follow hardware level inputs: timer and external interrupt. A machine delegation mask gates every bit of the supervisor view. A bit that is not delegated reads as zero, and a supervisor write to it has no effect on the stored state.

Each bit in the supervisor view aliases the machine pending state, but each has its own write rule:
- The software bit is plain read-write.
- The timer and external bits are read-only and track their hardware inputs.
- The overflow bit is read-write, and a hardware pulse can also set it. When the pulse and a software write land on the same edge, the pulse wins.

The unmasked machine pending vector is driven out to the interrupt arbiter. It can also be read at a second CSR address, so the alias behaviour can be confirmed from outside the block. Hypervisor and guest interrupt bits never appear in either view.

Top module: `irq_pend_view`

## Requirements
- R1: After reset, the stored software-pending bit (bit 1) and overflow-pending bit (bit 13) are 0, so `m_pend` reads 0 while the timer and external levels are low.
- R2: If `deleg_mask[k]` is 0 for k in {1,5,9,13}, bit k of the supervisor view (address 0x144) reads 0. A supervisor write to that bit leaves `m_pend[k]` unchanged.
- R3: With `deleg_mask[1]`=1, a write at 0x144 sets `m_pend[1]` to `csr_wdata[1]` on the next rising edge. A later supervisor read returns that value in bit 1.
- R4: With delegation set, supervisor bit 5 equals `hw_timer_lvl` and bit 9 equals `hw_ext_lvl`. Supervisor writes do not change either bit.
- R5: With `deleg_mask[13]`=1, a one-cycle `hw_ovf_set` pulse sets bit 13 on the next edge. A supervisor write of 0 to bit 13 clears it.
- R6: When `hw_ovf_set` and a supervisor write of 0 to bit 13 arrive in the same cycle, bit 13 is 1 after the edge.
- R7: Every supervisor-view bit other than 1, 5, 9 and 13 reads 0, even with `deleg_mask` all ones. Hypervisor-related bits 2, 6, 10 and 12 never appear.
- R8: A read at 0x344 returns the machine pending vector unmasked, whatever `deleg_mask` holds. `m_pend` carries the same vector at all times.
- R9: A read at any address other than 0x144 or 0x344 returns 0. A write there changes no state. Reads are combinational from the current state.
- R10: With `deleg_mask[13]`=1, a supervisor write of 1 to bit 13 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | Write strobe, sampled on the rising edge |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Combinational read data for `csr_addr` |
| deleg_mask | input | 64 | Machine delegation mask, one bit per interrupt cause |
| hw_timer_lvl | input | 1 | Timer interrupt pending level |
| hw_ext_lvl | input | 1 | External interrupt pending level |
| hw_ovf_set | input | 1 | One-cycle counter overflow set pulse |
| m_pend | output | 64 | Machine pending vector for the arbiter |

## Verification
The assertions take for granted that `csr_addr`, `csr_we` and `deleg_mask` are stable across each rising edge. They also assume the hardware levels change only between edges, so that `$past` of the write data and the delegation bit describes the write that took effect. The bench keeps within this by changing every input on the falling clock edge and holding it through the following rising edge. It samples read data one nanosecond after any combinational change.

// File: rtl/ipv_pkg.sv
package ipv_pkg;
   typedef enum logic [1:0] {
      CELL_RW  = 2'd0,
      CELL_RWH = 2'd1,
      CELL_ROH = 2'd2
   } cell_kind_e;

   localparam int NSRC = 4;
endpackage

// File: rtl/ipv_pend_cell.sv
module ipv_pend_cell
   import ipv_pkg::*;
#(
   parameter cell_kind_e KIND = CELL_RW
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_we,
   input  logic sw_d,
   input  logic hw_set,
   input  logic hw_lvl,
   output logic q
);
   logic unused_cell;
   assign unused_cell = &{1'b0, sw_we, sw_d, hw_set, hw_lvl};

   generate
      if (KIND == CELL_RW) begin : g_rw
         logic st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     st <= 1'b0;
            else if (sw_we) st <= sw_d;
         end
         assign q = st;
      end else if (KIND == CELL_RWH) begin : g_rwh
         logic st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st <= 1'b0;
            else if (hw_set) st <= 1'b1;
            else if (sw_we)  st <= sw_d;
         end
         assign q = st;
      end else begin : g_roh
         assign q = hw_lvl;
      end
   endgenerate
endmodule

// File: rtl/ipv_decode.sv
module ipv_decode #(
   parameter int          ADDR_W = 12,
   parameter int unsigned S_ADDR = 'h144,
   parameter int unsigned M_ADDR = 'h344
) (
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_we,
   output logic              s_hit,
   output logic              m_hit,
   output logic              s_wr
);
   localparam logic [ADDR_W-1:0] S_A = ADDR_W'(S_ADDR);
   localparam logic [ADDR_W-1:0] M_A = ADDR_W'(M_ADDR);

   generate
      if (S_A == M_A) begin : g_bad_map
         $error("supervisor and machine view addresses collide");
      end
   endgenerate

   assign s_hit = (csr_addr == S_A);
   assign m_hit = (csr_addr == M_A);
   assign s_wr  = s_hit & csr_we;
endmodule

// File: rtl/ipv_view.sv
module ipv_view #(
   parameter int              XLEN = 64,
   parameter logic [XLEN-1:0] VIS  = '0
) (
   input  logic [XLEN-1:0] m_pend,
   input  logic [XLEN-1:0] deleg,
   output logic [XLEN-1:0] s_view
);
   generate
      for (genvar b = 0; b < XLEN; b++) begin : g_bit
         if (VIS[b]) begin : g_vis
            assign s_view[b] = m_pend[b] & deleg[b];
         end else begin : g_hid
            assign s_view[b] = 1'b0;
         end
      end
   endgenerate

   logic unused_view;
   assign unused_view = &{1'b0, m_pend & ~VIS, deleg & ~VIS};
endmodule

// File: rtl/irq_pend_view.sv
module irq_pend_view
   import ipv_pkg::*;
#(
   parameter int          XLEN      = 64,
   parameter int          ADDR_W    = 12,
   parameter int unsigned S_ADDR    = 'h144,
   parameter int unsigned M_ADDR    = 'h344,
   parameter int          SOFT_BIT  = 1,
   parameter int          TIMER_BIT = 5,
   parameter int          EXT_BIT   = 9,
   parameter int          OVF_BIT   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_we,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic [XLEN-1:0]   deleg_mask,
   input  logic              hw_timer_lvl,
   input  logic              hw_ext_lvl,
   input  logic              hw_ovf_set,
   output logic [XLEN-1:0]   m_pend
);
   localparam int         POS  [NSRC] = '{SOFT_BIT, TIMER_BIT, EXT_BIT, OVF_BIT};
   localparam cell_kind_e KIND [NSRC] = '{CELL_RW, CELL_ROH, CELL_ROH, CELL_RWH};

   function automatic logic [XLEN-1:0] vis_mask();
      logic [XLEN-1:0] m;
      m = '0;
      for (int i = 0; i < NSRC; i++) m[POS[i]] = 1'b1;
      return m;
   endfunction
   localparam logic [XLEN-1:0] VIS = vis_mask();

   generate
      if (XLEN < 14 || SOFT_BIT >= XLEN || TIMER_BIT >= XLEN ||
          EXT_BIT >= XLEN || OVF_BIT >= XLEN) begin : g_bad_width
         $error("interrupt bit position outside XLEN");
      end
      if ($countones(VIS) != NSRC) begin : g_bad_pos
         $error("interrupt bit positions must be distinct");
      end
   endgenerate

   logic s_hit, m_hit, s_wr;

   ipv_decode #(
      .ADDR_W (ADDR_W),
      .S_ADDR (S_ADDR),
      .M_ADDR (M_ADDR)
   ) u_dec (
      .csr_addr (csr_addr),
      .csr_we   (csr_we),
      .s_hit    (s_hit),
      .m_hit    (m_hit),
      .s_wr     (s_wr)
   );

   logic [NSRC-1:0] hw_set_v, hw_lvl_v, src_q;
   assign hw_set_v = {hw_ovf_set, 1'b0, 1'b0, 1'b0};
   assign hw_lvl_v = {1'b0, hw_ext_lvl, hw_timer_lvl, 1'b0};

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         ipv_pend_cell #(.KIND(KIND[i])) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_we  (s_wr & deleg_mask[POS[i]]),
            .sw_d   (csr_wdata[POS[i]]),
            .hw_set (hw_set_v[i]),
            .hw_lvl (hw_lvl_v[i]),
            .q      (src_q[i])
         );
      end
   endgenerate

   always_comb begin
      m_pend = '0;
      for (int i = 0; i < NSRC; i++) m_pend[POS[i]] = src_q[i];
   end

   logic [XLEN-1:0] s_view;

   ipv_view #(.XLEN(XLEN), .VIS(VIS)) u_view (
      .m_pend (m_pend),
      .deleg  (deleg_mask),
      .s_view (s_view)
   );

   always_comb begin
      if (s_hit)      csr_rdata = s_view;
      else if (m_hit) csr_rdata = m_pend;
      else            csr_rdata = '0;
   end

   logic unused_top;
   assign unused_top = &{1'b0, csr_wdata & ~VIS};
endmodule

// File: rtl/ipv_checker.sv
module ipv_checker #(
   parameter int          XLEN      = 64,
   parameter int          ADDR_W    = 12,
   parameter int unsigned S_ADDR    = 'h144,
   parameter int unsigned M_ADDR    = 'h344,
   parameter int          SOFT_BIT  = 1,
   parameter int          TIMER_BIT = 5,
   parameter int          EXT_BIT   = 9,
   parameter int          OVF_BIT   = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] csr_addr,
   input logic              csr_we,
   input logic [XLEN-1:0]   csr_wdata,
   input logic [XLEN-1:0]   csr_rdata,
   input logic [XLEN-1:0]   deleg_mask,
   input logic              hw_timer_lvl,
   input logic              hw_ext_lvl,
   input logic              hw_ovf_set,
   input logic [XLEN-1:0]   m_pend
);
   localparam logic [ADDR_W-1:0] S_A = ADDR_W'(S_ADDR);
   localparam logic [ADDR_W-1:0] M_A = ADDR_W'(M_ADDR);
   localparam logic [XLEN-1:0] VIS = (XLEN'(1) << SOFT_BIT) | (XLEN'(1) << TIMER_BIT) |
                                     (XLEN'(1) << EXT_BIT)  | (XLEN'(1) << OVF_BIT);

   logic s_at, m_at, soft_wr;
   assign s_at    = (csr_addr == S_A);
   assign m_at    = (csr_addr == M_A);
   assign soft_wr = csr_we && s_at && deleg_mask[SOFT_BIT];

   AST_SV_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      s_at |-> ((csr_rdata & ~VIS) == '0)); // R7
   AST_SV_UNDELEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      s_at |-> ((csr_rdata & ~deleg_mask) == '0)); // R2
   AST_SOFT_ALIAS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_wr |=> (m_pend[SOFT_BIT] == $past(csr_wdata[SOFT_BIT]))); // R3
   AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_wr |=> $stable(m_pend[SOFT_BIT])); // R2
   AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hw_ovf_set |=> m_pend[OVF_BIT]); // R6
   AST_TIMER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      m_pend[TIMER_BIT] == hw_timer_lvl); // R4
   AST_EXT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      m_pend[EXT_BIT] == hw_ext_lvl); // R4
   AST_MVIEW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      m_at |-> (csr_rdata == m_pend)); // R8
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_at && !m_at) |-> (csr_rdata == '0)); // R9

   logic unused_chk;
   assign unused_chk = &{1'b0, csr_wdata};
endmodule

bind irq_pend_view ipv_checker #(
   .XLEN(XLEN), .ADDR_W(ADDR_W), .S_ADDR(S_ADDR), .M_ADDR(M_ADDR),
   .SOFT_BIT(SOFT_BIT), .TIMER_BIT(TIMER_BIT), .EXT_BIT(EXT_BIT), .OVF_BIT(OVF_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
   .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .deleg_mask(deleg_mask),
   .hw_timer_lvl(hw_timer_lvl), .hw_ext_lvl(hw_ext_lvl),
   .hw_ovf_set(hw_ovf_set), .m_pend(m_pend)
);

// File: tb/irq_pend_view_tb.sv
module irq_pend_view_tb;
   localparam logic [11:0] SA = 12'h144;
   localparam logic [11:0] MA = 12'h344;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = 12'h000;
   logic        csr_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic [63:0] deleg_mask = '0;
   logic        hw_timer_lvl = 1'b0;
   logic        hw_ext_lvl = 1'b0;
   logic        hw_ovf_set = 1'b0;
   logic [63:0] m_pend;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_pend_view u_dut (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .deleg_mask(deleg_mask),
      .hw_timer_lvl(hw_timer_lvl), .hw_ext_lvl(hw_ext_lvl),
      .hw_ovf_set(hw_ovf_set), .m_pend(m_pend)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic csr_read(input logic [11:0] a, output logic [63:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic ovf_pulse();
      @(negedge clk);
      hw_ovf_set = 1'b1;
      @(negedge clk);
      hw_ovf_set = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      chk("R1 m_pend after reset", m_pend, 64'h0);
      csr_read(MA, d);
      chk("R1 machine view after reset", d, 64'h0);
   endtask

   task automatic t_undeleg();
      logic [63:0] d;
      deleg_mask = '0;
      hw_timer_lvl = 1'b1; hw_ext_lvl = 1'b1;
      csr_write(SA, '1);
      csr_read(SA, d);
      chk("R2 undelegated supervisor read", d, 64'h0);
      chk("R2 undelegated write leaves state", m_pend, 64'h0220);
      hw_timer_lvl = 1'b0; hw_ext_lvl = 1'b0;
   endtask

   task automatic t_soft_alias();
      logic [63:0] d;
      deleg_mask = 64'h2;
      csr_write(SA, 64'h2);
      chk("R3 m_pend bit1 after write", m_pend, 64'h2);
      csr_read(SA, d);
      chk("R3 supervisor readback", d, 64'h2);
      csr_write(SA, 64'h0);
      csr_read(MA, d);
      chk("R3 machine view cleared", d, 64'h0);
   endtask

   task automatic t_hw_views();
      logic [63:0] d;
      deleg_mask = 64'h0220;
      hw_timer_lvl = 1'b1;
      csr_read(SA, d);
      chk("R4 timer visible", d, 64'h0020);
      csr_write(SA, 64'h0);
      hw_ext_lvl = 1'b1;
      csr_read(SA, d);
      chk("R4 write ignored, both levels", d, 64'h0220);
      hw_timer_lvl = 1'b0;
      #1 chk("R4 timer follows level", csr_rdata, 64'h0200);
      hw_ext_lvl = 1'b0;
   endtask

   task automatic t_ovf();
      logic [63:0] d;
      deleg_mask = 64'h2000;
      ovf_pulse();
      csr_read(SA, d);
      chk("R5 overflow set by pulse", d, 64'h2000);
      csr_write(SA, 64'h0);
      chk("R5 overflow cleared by write 0", m_pend, 64'h0);
      csr_write(SA, 64'h2000);
      chk("R10 overflow set by write 1", m_pend, 64'h2000);
      csr_write(SA, 64'h0);
   endtask

   task automatic t_collide();
      @(negedge clk);
      deleg_mask = 64'h2000;
      csr_addr = SA; csr_wdata = '0; csr_we = 1'b1; hw_ovf_set = 1'b1;
      @(negedge clk);
      csr_we = 1'b0; hw_ovf_set = 1'b0;
      chk("R6 set beats clear", m_pend, 64'h2000);
      csr_write(SA, 64'h0);
      chk("R6 clear afterwards", m_pend, 64'h0);
   endtask

   task automatic t_hidden();
      logic [63:0] d;
      deleg_mask = '1;
      hw_timer_lvl = 1'b1;
      csr_write(SA, '1);
      csr_read(SA, d);
      chk("R7 only mapped bits visible", d, 64'h2022);
      csr_write(SA, 64'h0);
      hw_timer_lvl = 1'b0;
   endtask

   task automatic t_mview();
      logic [63:0] d;
      deleg_mask = 64'h2002;
      csr_write(SA, 64'h2002);
      deleg_mask = '0;
      hw_ext_lvl = 1'b1;
      csr_read(MA, d);
      chk("R8 machine view unmasked", d, 64'h2202);
      chk("R8 m_pend matches", m_pend, 64'h2202);
      hw_ext_lvl = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [63:0] d;
      csr_read(12'h100, d);
      chk("R9 unmapped read zero", d, 64'h0);
      deleg_mask = '1;
      csr_write(12'h100, 64'h0);
      chk("R9 unmapped write no effect", m_pend, 64'h2002);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_undeleg();
      t_soft_alias();
      t_hw_views();
      t_ovf();
      t_collide();
      t_hidden();
      t_mview();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule